// File: doc/BRIEF.md
# ADC Peak Level Detector

This block watches the sample stream of each ADC channel and remembers how loud the loudest sample has been since software last looked. The peak is held as a 6-bit attenuation code: each step is 1 dB below full scale, so 0 stands for a full-scale sample and 63 for a level 63 dB down or quieter. Software reads a channel by pulsing its read strobe. The code present in that cycle is the returned value, and the read also clears the stored peak so that a new measurement window starts.

Capture runs only while the channel's peak-enable bit is set. While the bit is low, the channel holds the floor code and ignores samples. A new window therefore starts whenever the bit is raised. The top module holds one independent detector per channel, two by default, for left and right. The dB conversion uses a fixed set of thresholds that elaboration computes. Nothing is computed in dB at run time.

Top module: `pkm_stereo_peak`

## Requirements
- R1: After reset, every channel's code is 63 (the floor).
- R2: The threshold for step k is T(0) = 2^(W-1)-1 and T(k+1) = floor(T(k)*58409/65536). A captured sample maps to the smallest k in 0..63 for which its magnitude is at least T(k). It maps to 63 when no threshold is met.
- R3: The magnitude of a sample is its two's-complement absolute value. The most negative code saturates to 2^(W-1)-1, so it maps to step 0.
- R4: While the channel is enabled and not read, its code never rises. A valid sample lowers the code to that sample's step when the step is smaller than the held code.
- R5: A read with no valid sample in the same cycle sets the code to 63 in the next cycle.
- R6: When a read and a valid sample fall in the same cycle, the read sees the code from before that sample. In the next cycle the code equals that sample's own step.
- R7: While the peak-enable bit is 0, the code is 63 from the next cycle on, and valid samples are ignored.
- R8: A sample whose valid strobe is 0 leaves the code unchanged.
- R9: The channels are independent. Activity on one channel never changes another channel's code.
- R10: The code is registered. A sample in cycle N is reflected in the code from cycle N+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_i | input | NCH*W | Signed ADC sample per channel |
| smp_vld_i | input | NCH | Sample valid strobe per channel |
| pk_en_i | input | NCH | Peak capture enable per channel |
| rd_i | input | NCH | Read strobe per channel; clears the peak after this cycle |
| pk_code_o | output | NCH*6 | Held peak code per channel, 0 = full scale, 63 = floor |

## Verification
The step mapping is swept over every threshold. Each threshold is applied exactly, and its value minus one is applied with a negative sign. This separates an off-by-one comparison, a wrong step constant and a sign-handling fault. The most negative and second most negative codes show whether saturation is handled or the magnitude wraps. Short directed sequences cover each window rule on its own: a loud sample followed by quieter ones, a read in an idle cycle, a read together with a sample, an invalid loud sample, and a disabled channel. After these, a long pseudo-random run with rare reads and enable drops is compared cycle by cycle against an arithmetic model on both channels, so that any crosstalk between channels shows.

// File: rtl/pkm_pkg.sv
package pkm_pkg;

    localparam int CODE_W     = 6;
    localparam int N_STEPS    = 1 << CODE_W;
    localparam int STEP_MUL   = 58409;   // 2^16 * 10^(-1/20), rounded
    localparam int STEP_SHIFT = 16;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_FLOOR = code_t'(N_STEPS - 1);

    typedef struct packed {
        code_t level;
    } chan_state_t;

    // Magnitude threshold for step k, for a W-bit signed sample.
    function automatic logic [63:0] step_thresh(input int unsigned w, input int unsigned k);
        logic [63:0] t;
        t = (64'd1 << (w - 1)) - 64'd1;
        for (int unsigned i = 0; i < k; i++) begin
            t = (t * 64'(STEP_MUL)) >> STEP_SHIFT;
        end
        return t;
    endfunction

endpackage

// File: rtl/pkm_magnitude.sv
module pkm_magnitude #(
    parameter int W = 16
) (
    input  logic [W-1:0] smp_i,
    output logic [W-2:0] mag_o
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] neg;

    always_comb begin
        neg = (~smp_i) + ONE;
        if (smp_i == MOST_NEG) begin
            mag_o = {(W-1){1'b1}};
        end else if (smp_i[W-1]) begin
            mag_o = neg[W-2:0];
        end else begin
            mag_o = smp_i[W-2:0];
        end
    end
endmodule

// File: rtl/pkm_level_encoder.sv
module pkm_level_encoder
    import pkm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-2:0] mag_i,
    output code_t        code_o
);
    logic [N_STEPS-1:0] hit;

    for (genvar k = 0; k < N_STEPS; k++) begin : g_step
        localparam logic [63:0]  T_FULL = step_thresh(W, k);
        localparam logic [W-2:0] T_K    = T_FULL[W-2:0];
        assign hit[k] = (mag_i >= T_K);
    end

    always_comb begin
        code_o = CODE_FLOOR;
        for (int k = N_STEPS - 1; k >= 0; k--) begin
            if (hit[k]) begin
                code_o = code_t'(k);
            end
        end
    end
endmodule

// File: rtl/pkm_channel.sv
module pkm_channel
    import pkm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en_i,
    input  logic  rd_i,
    input  logic  vld_i,
    input  code_t code_i,
    output code_t level_o
);
    chan_state_t st_d, st_q;
    code_t       base;

    always_comb begin
        st_d = st_q;
        base = st_q.level;
        if (!en_i) begin
            st_d.level = CODE_FLOOR;
        end else begin
            if (rd_i) begin
                base = CODE_FLOOR;
            end
            if (vld_i && (code_i < base)) begin
                st_d.level = code_i;
            end else begin
                st_d.level = base;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.level <= CODE_FLOOR;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;
endmodule

// File: rtl/pkm_stereo_peak.sv
module pkm_stereo_peak
    import pkm_pkg::*;
#(
    parameter int W   = 16,
    parameter int NCH = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NCH-1:0][W-1:0]        smp_i,
    input  logic [NCH-1:0]               smp_vld_i,
    input  logic [NCH-1:0]               pk_en_i,
    input  logic [NCH-1:0]               rd_i,
    output logic [NCH-1:0][CODE_W-1:0]   pk_code_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [W-2:0] mag;
        code_t        smp_code;
        code_t        level;

        pkm_magnitude #(.W(W)) u_mag (
            .smp_i (smp_i[c]),
            .mag_o (mag)
        );

        pkm_level_encoder #(.W(W)) u_enc (
            .mag_i  (mag),
            .code_o (smp_code)
        );

        pkm_channel u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (pk_en_i[c]),
            .rd_i    (rd_i[c]),
            .vld_i   (smp_vld_i[c]),
            .code_i  (smp_code),
            .level_o (level)
        );

        assign pk_code_o[c] = level;
    end
endmodule

// File: rtl/pkm_checker.sv
module pkm_checker
    import pkm_pkg::*;
#(
    parameter int W   = 16,
    parameter int NCH = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NCH-1:0][W-1:0]      smp_i,
    input logic [NCH-1:0]             smp_vld_i,
    input logic [NCH-1:0]             pk_en_i,
    input logic [NCH-1:0]             rd_i,
    input logic [NCH-1:0][CODE_W-1:0] pk_code_o
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        AST_DISABLED_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
            !pk_en_i[c] |=> pk_code_o[c] == CODE_FLOOR); // R7

        AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_i[c] && !smp_vld_i[c]) |=> pk_code_o[c] == CODE_FLOOR); // R5

        AST_HOLD_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_n)
            (pk_en_i[c] && !rd_i[c]) |=> pk_code_o[c] <= $past(pk_code_o[c])); // R4

        AST_INVALID_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (pk_en_i[c] && !rd_i[c] && !smp_vld_i[c]) |=> $stable(pk_code_o[c])); // R8

        AST_MOST_NEG_FULL: assert property (@(posedge clk) disable iff (!rst_n)
            (pk_en_i[c] && smp_vld_i[c] && smp_i[c] == MOST_NEG) |=> pk_code_o[c] == '0); // R3
    end
endmodule

bind pkm_stereo_peak pkm_checker #(.W(W), .NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_i     (smp_i),
    .smp_vld_i (smp_vld_i),
    .pk_en_i   (pk_en_i),
    .rd_i      (rd_i),
    .pk_code_o (pk_code_o)
);

// File: tb/pkm_stereo_peak_tb.sv
`timescale 1ns/1ps
module pkm_stereo_peak_tb;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0][15:0] smp = '0;
    logic [1:0]       vld = '0;
    logic [1:0]       en = '0;
    logic [1:0]       rd = '0;
    logic [1:0][5:0]  code;

    int   n_chk = 0;
    int   n_bad = 0;
    int   exp_code [2];
    longint thr [64];
    logic done = 1'b0;

    always #2 clk = ~clk;

    pkm_stereo_peak #(.W(16), .NCH(2)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_i     (smp),
        .smp_vld_i (vld),
        .pk_en_i   (en),
        .rd_i      (rd),
        .pk_code_o (code)
    );

    // Step of one sample per R2 / R3
    function automatic int step_of(input logic [15:0] s);
        longint m;
        if (s == 16'h8000)   m = 32767;
        else if (s[15])      m = 65536 - longint'(s);
        else                 m = longint'(s);
        for (int k = 0; k < 64; k++) begin
            if (m >= thr[k]) return k;
        end
        return 63;
    endfunction

    task automatic check(input int ch, input int exp, input string tag);
        n_chk++;
        if (int'(code[ch]) != exp) begin
            n_bad++;
            $display("FAIL %s ch%0d: actual %0d expected %0d", tag, ch, code[ch], exp);
        end
    endtask

    // One cycle: check current outputs, then drive inputs and advance the model.
    task automatic cyc(input logic v0, input logic [15:0] s0, input logic e0, input logic r0,
                       input logic v1, input logic [15:0] s1, input logic e1, input logic r1,
                       input string tag);
        logic       v [2];
        logic [15:0] s [2];
        logic       e [2];
        logic       r [2];
        @(negedge clk);
        check(0, exp_code[0], tag);
        check(1, exp_code[1], tag);
        v[0] = v0; s[0] = s0; e[0] = e0; r[0] = r0;
        v[1] = v1; s[1] = s1; e[1] = e1; r[1] = r1;
        for (int c = 0; c < 2; c++) begin
            int base;
            smp[c] = s[c]; vld[c] = v[c]; en[c] = e[c]; rd[c] = r[c];
            if (!e[c]) begin
                exp_code[c] = 63;
            end else begin
                base = r[c] ? 63 : exp_code[c];
                if (v[c] && step_of(s[c]) < base) exp_code[c] = step_of(s[c]);
                else                             exp_code[c] = base;
            end
        end
    endtask

    initial begin
        #(1_000_000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        thr[0] = 32767;
        for (int k = 1; k < 64; k++) thr[k] = (thr[k-1] * 58409) >>> 16;
        exp_code[0] = 63;
        exp_code[1] = 63;

        repeat (3) @(negedge clk);
        check(0, 63, "R1");
        check(1, 63, "R1");
        rst_n = 1'b1;

        // R7: disabled channel ignores loud samples
        cyc(1, 16'h7fff, 0, 0, 1, 16'h8000, 0, 0, "R7");
        cyc(1, 16'h7fff, 0, 0, 1, 16'h8000, 0, 0, "R7");
        cyc(0, 16'h0000, 1, 1, 0, 16'h0000, 1, 1, "R7");

        // R2: every threshold exactly, and one below it with negative sign
        for (int k = 0; k < 64; k++) begin
            cyc(1, 16'(thr[k]), 1, 1, 0, 0, 1, 0, "R2");
            cyc(1, 16'(-(thr[k] - 1)), 1, 1, 0, 0, 1, 0, "R2");
            cyc(0, 0, 1, 0, 0, 0, 1, 0, "R2");
        end

        // R3: saturation of the most negative code
        cyc(1, 16'h8000, 1, 1, 0, 0, 1, 0, "R3");
        cyc(0, 0, 1, 0, 0, 0, 1, 0, "R3");
        cyc(1, 16'h8001, 1, 1, 0, 0, 1, 0, "R3");
        cyc(0, 0, 1, 0, 0, 0, 1, 0, "R3");

        // R4 / R10: quieter samples after a loud one do not raise the code
        cyc(1, 16'd1000, 1, 1, 0, 0, 1, 0, "R10");
        cyc(1, 16'd100, 1, 0, 0, 0, 1, 0, "R4");
        cyc(1, 16'hfc18, 1, 0, 0, 0, 1, 0, "R4");
        cyc(1, 16'd9000, 1, 0, 0, 0, 1, 0, "R4");
        cyc(0, 0, 1, 0, 0, 0, 1, 0, "R4");

        // R5: read without a sample clears
        cyc(0, 0, 1, 1, 0, 0, 1, 0, "R5");
        cyc(0, 0, 1, 0, 0, 0, 1, 0, "R5");

        // R6: read with a sample keeps the old value for the read
        cyc(1, 16'h7000, 1, 0, 0, 0, 1, 0, "R6");
        cyc(1, 16'd50, 1, 1, 0, 0, 1, 0, "R6");
        cyc(0, 0, 1, 0, 0, 0, 1, 0, "R6");

        // R8: invalid loud sample ignored
        cyc(0, 16'h7fff, 1, 0, 0, 16'h8000, 1, 0, "R8");
        cyc(0, 16'h8000, 1, 0, 0, 16'h7fff, 1, 0, "R8");

        // R9: loud channel 0, idle enabled channel 1
        cyc(1, 16'h7fff, 1, 1, 0, 0, 1, 1, "R9");
        cyc(1, 16'h8000, 1, 0, 0, 16'h7fff, 1, 0, "R9");
        cyc(0, 0, 1, 0, 1, 16'd10, 1, 0, "R9");

        // R4: pseudo-random mix on both channels
        lfsr = 32'h1ace_b00c;
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a, b;
            logic [7:0]  ctl;
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            a = lfsr[31:16] >> lfsr[3:0];
            if (lfsr[4]) a = -a;
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            b = lfsr[31:16] >> lfsr[3:0];
            if (lfsr[4]) b = -b;
            ctl = lfsr[15:8];
            cyc(ctl[0] | ctl[1], a, ctl[7:5] != 3'd0, ctl[4:2] == 3'd0,
                ctl[1] | ctl[6], b, ctl[7:6] != 2'd0, ctl[3:1] == 3'd7, "R4");
        end
        cyc(0, 0, 1, 0, 0, 0, 1, 0, "R4");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule